// File: doc/BRIEF.md
# BCD Calendar With Alarm Match

This block keeps the time of day and the calendar date and moves them forward by one second for every accepted pulse on its one-per-second input. The running time is held internally as plain binary numbers. A separate set of visible bytes presents that time to the rest of the chip as packed BCD or as binary, with either a 24-hour clock or a 12-hour clock with a PM flag. Every accepted second opens an update window. While the window is open the update-in-progress flag is high. When it closes, the visible bytes are refreshed, the alarm bytes are compared, and one-cycle request pulses are raised for the alarm flag and the update-ended flag.

A host writes time fields through a byte-wide load port. A SET input freezes the visible bytes so that all of them can be rewritten without the counter disturbing them. When SET is released, the internal time is rebuilt from the visible bytes. An oscillator control field gates counting: any code other than the run code freezes the clock. The century used for the leap-year rule is a parameter.

Top module: `cal_bcd_clock`

## Requirements
- R1: After reset the visible bytes read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day-of-month 0x01, month 0x01, year 0x00, and uip, alarm_req and upd_req are all 0.
- R2: A second pulse is accepted only while osc_sel equals 3'b010. Under any other code the pulse is ignored: the time does not advance, uip stays 0, and no request pulse appears.
- R3: An accepted pulse raises uip from the next cycle for exactly UIP_CYCLES cycles (default 8). The refresh and the request pulses occur at the edge that ends this window. Pulses that arrive while a window is open are ignored.
- R4: With bin_mode=1 every visible, loaded and alarm byte is plain binary. With bin_mode=0 it is packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R5: With h24_mode=1 the hour byte shows 0 to 23. With h24_mode=0 bits 6:0 show the hour modulo 12 and bit 7 is set for hours 12 to 23, so noon shows as 0x80 in BCD.
- R6: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. The weekday cycles from 0 to 6, the month from 1 to 12, and the year from 0 to 99, each carrying into the next larger field.
- R7: Month lengths follow the Gregorian rule applied to the year CENTURY*100+year (default century 20). February has 29 days when that year is divisible by 4 and either not divisible by 100 or divisible by 400.
- R8: A day-of-month of 0 advances to 1 at midnight and the month does not change.
- R9: With alarm_en=1, alarm_req pulses for one cycle at the end of a window when each of the three alarm bytes either has bits 7:6 equal to 2'b11 (matches any value) or decodes to the current second, minute or hour in the selected format.
- R10: With upd_en=1, upd_req pulses for one cycle at the end of every window. With upd_en=0 it stays low.
- R11: While set_mode=1 the visible bytes are not refreshed and uip stays 0, but the internal time still advances and the alarm is still compared against it. When set_mode falls, the internal time is rebuilt from the visible bytes.
- R12: A cycle with ld_en=1 writes ld_data into the visible byte chosen by ld_sel (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day-of-month, 5 month, 6 year) at the next edge. If set_mode=0 at that edge, the internal time is rebuilt from the visible bytes, including the new one. A load takes precedence over a refresh or advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_sel | input | 3 | Oscillator control; 3'b010 runs the clock |
| set_mode | input | 1 | Freeze the visible bytes for host writes |
| bin_mode | input | 1 | 1 selects binary, 0 selects packed BCD |
| h24_mode | input | 1 | 1 selects the 24-hour format |
| alarm_en | input | 1 | Enable alarm requests |
| upd_en | input | 1 | Enable update-ended requests |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hr | input | 8 | Hours alarm byte |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field chosen for the load |
| ld_data | input | 8 | Byte to load |
| out_sec | output | 8 | Visible seconds |
| out_min | output | 8 | Visible minutes |
| out_hr | output | 8 | Visible hours |
| out_wday | output | 8 | Visible weekday |
| out_mday | output | 8 | Visible day-of-month |
| out_mon | output | 8 | Visible month |
| out_yr | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| alarm_req | output | 1 | Alarm flag request pulse |
| upd_req | output | 1 | Update-ended flag request pulse |

## Verification
The counter is driven through directed starting points: a plain mid-minute second, 11:59:59 and 23:59:59 in the 12-hour format, February 28 in a leap year, a common year and the century year, New Year's Eve of year 99, and a zero day-of-month. Together these separate a carry chain that is wrong at one particular link from a format or encoding fault. A randomized phase then loads times close to minute, hour, day and month boundaries in all four format combinations and runs several seconds from each. It also picks alarm bytes that are wildcards, exact matches or near misses, which separates a faulty wildcard decode from a faulty value compare. Further cases pulse the second input with a stopped oscillator, pulse it again inside an open window, and tick under SET to show that the hidden time advances while the visible bytes stay fixed.

// File: rtl/cal_bcd_pkg.sv
package cal_bcd_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HR   = 2;
  localparam int FLD_WDAY = 3;
  localparam int FLD_MDAY = 4;
  localparam int FLD_MON  = 5;
  localparam int FLD_YR   = 6;

  localparam logic [2:0] OSC_RUN = 3'b010;
  localparam logic [1:0] ALM_ANY = 2'b11;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [6:0] wday;
    logic [6:0] mday;
    logic [6:0] mon;
    logic [6:0] yr;
  } cal_time_t;

  // binary value -> visible byte (binary or packed BCD)
  function automatic logic [7:0] enc_field(input logic [6:0] val, input logic bin);
    logic [7:0] w, tens, ones;
    w    = {1'b0, val};
    tens = w / 8'd10;
    ones = w % 8'd10;
    return bin ? w : {tens[3:0], ones[3:0]};
  endfunction

  // visible byte -> binary value
  function automatic logic [6:0] dec_field(input logic [7:0] code, input logic bin);
    logic [7:0] v;
    v = bin ? code : (({4'd0, code[7:4]} * 8'd10) + {4'd0, code[3:0]});
    return v[6:0];
  endfunction

  function automatic logic [7:0] enc_hour(input logic [6:0] hr, input logic bin,
                                          input logic h24);
    logic pm;
    if (h24) return enc_field(hr, bin);
    pm = (hr >= 7'd12);
    return enc_field(hr % 7'd12, bin) | {pm, 7'd0};
  endfunction

  function automatic logic [6:0] dec_hour(input logic [7:0] code, input logic bin,
                                          input logic h24);
    logic [6:0] h;
    h = dec_field({1'b0, code[6:0]}, bin);
    if (!h24 && code[7]) h = h + 7'd12;
    return h;
  endfunction

  function automatic logic is_leap(input logic [6:0] yr, input int century);
    int full;
    full = century * 100 + int'(yr);
    return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr,
                                            input int century);
    case (mon)
      7'd2:                       return is_leap(yr, century) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  // one second forward, each field carrying into the next
  function automatic cal_time_t next_second(input cal_time_t t, input int century);
    cal_time_t n;
    n = t;
    if (t.sec < 7'd59) n.sec = t.sec + 7'd1;
    else begin
      n.sec = '0;
      if (t.min < 7'd59) n.min = t.min + 7'd1;
      else begin
        n.min = '0;
        if (t.hr < 7'd23) n.hr = t.hr + 7'd1;
        else begin
          n.hr   = '0;
          n.wday = (t.wday >= 7'd6) ? 7'd0 : t.wday + 7'd1;
          if (t.mday < month_days(t.mon, t.yr, century)) n.mday = t.mday + 7'd1;
          else begin
            n.mday = 7'd1;
            if (t.mon < 7'd12) n.mon = t.mon + 7'd1;
            else begin
              n.mon = 7'd1;
              n.yr  = (t.yr >= 7'd99) ? 7'd0 : t.yr + 7'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_bcd_pkg::*;
#(
  parameter int CENTURY = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      reload,
  input  cal_time_t reload_val,
  output cal_time_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      cur.mday <= 7'd1;
      cur.mon  <= 7'd1;
    end else if (reload) begin
      cur <= reload_val;
    end else if (advance) begin
      cur <= next_second(cur, CENTURY);
    end
  end

endmodule

// File: rtl/cal_upd_window.sv
module cal_upd_window #(
  parameter int UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic busy,
  output logic win_end,
  output logic uip
);

  localparam int CNT_W = $clog2(UIP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UIP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_end = busy && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      uip   <= 1'b0;
    end else begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (win_end) busy <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
      if (hold)         uip <= 1'b0;
      else if (start)   uip <= 1'b1;
      else if (win_end) uip <= 1'b0;
    end
  end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_bcd_pkg::*;
(
  input  cal_time_t  cur,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic       bin_mode,
  input  logic       h24_mode,
  output logic       hit
);

  logic sec_ok, min_ok, hr_ok;

  assign sec_ok = (alm_sec[7:6] == ALM_ANY) || (dec_field(alm_sec, bin_mode) == cur.sec);
  assign min_ok = (alm_min[7:6] == ALM_ANY) || (dec_field(alm_min, bin_mode) == cur.min);
  assign hr_ok  = (alm_hr[7:6]  == ALM_ANY) || (dec_hour(alm_hr, bin_mode, h24_mode) == cur.hr);
  assign hit    = sec_ok && min_ok && hr_ok;

endmodule

// File: rtl/cal_bcd_clock.sv
module cal_bcd_clock
  import cal_bcd_pkg::*;
#(
  parameter int UIP_CYCLES = 8,
  parameter int CENTURY    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_sel,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       alarm_en,
  input  logic       upd_en,
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hr,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] out_sec,
  output logic [7:0] out_min,
  output logic [7:0] out_hr,
  output logic [7:0] out_wday,
  output logic [7:0] out_mday,
  output logic [7:0] out_mon,
  output logic [7:0] out_yr,
  output logic       uip,
  output logic       alarm_req,
  output logic       upd_req
);

  logic [7:0] vis_q  [NUM_FIELDS];
  logic [7:0] vis_nx [NUM_FIELDS];
  logic [7:0] fresh  [NUM_FIELDS];

  logic      set_q, set_fall;
  logic      tick_ok, win_busy, win_end, reload, alarm_hit;
  cal_time_t cur_time, reload_time;

  // named events used by the checker
  assign tick_ok  = sec_tick && (osc_sel == OSC_RUN) && !win_busy;
  assign set_fall = set_q && !set_mode;
  assign reload   = (ld_en && !set_mode) || set_fall;

  // visible bytes as they stand after a pending load
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++)
      vis_nx[i] = (ld_en && (ld_sel == 3'(i))) ? ld_data : vis_q[i];
  end

  always_comb begin
    reload_time      = '0;
    reload_time.sec  = dec_field(vis_nx[FLD_SEC],  bin_mode);
    reload_time.min  = dec_field(vis_nx[FLD_MIN],  bin_mode);
    reload_time.hr   = dec_hour (vis_nx[FLD_HR],   bin_mode, h24_mode);
    reload_time.wday = dec_field(vis_nx[FLD_WDAY], bin_mode);
    reload_time.mday = dec_field(vis_nx[FLD_MDAY], bin_mode);
    reload_time.mon  = dec_field(vis_nx[FLD_MON],  bin_mode);
    reload_time.yr   = dec_field(vis_nx[FLD_YR],   bin_mode);
  end

  always_comb begin
    fresh[FLD_SEC]  = enc_field(cur_time.sec,  bin_mode);
    fresh[FLD_MIN]  = enc_field(cur_time.min,  bin_mode);
    fresh[FLD_HR]   = enc_hour (cur_time.hr,   bin_mode, h24_mode);
    fresh[FLD_WDAY] = enc_field(cur_time.wday, bin_mode);
    fresh[FLD_MDAY] = enc_field(cur_time.mday, bin_mode);
    fresh[FLD_MON]  = enc_field(cur_time.mon,  bin_mode);
    fresh[FLD_YR]   = enc_field(cur_time.yr,   bin_mode);
  end

  cal_time_core #(.CENTURY(CENTURY)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (tick_ok),
    .reload     (reload),
    .reload_val (reload_time),
    .cur        (cur_time)
  );

  cal_upd_window #(.UIP_CYCLES(UIP_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tick_ok),
    .hold    (set_mode),
    .busy    (win_busy),
    .win_end (win_end),
    .uip     (uip)
  );

  cal_alarm_cmp u_alm (
    .cur      (cur_time),
    .alm_sec  (alarm_sec),
    .alm_min  (alarm_min),
    .alm_hr   (alarm_hr),
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .hit      (alarm_hit)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_FIELDS; g++) begin : g_vis
      localparam logic [7:0] RST_CODE = ((g == FLD_MDAY) || (g == FLD_MON)) ? 8'h01 : 8'h00;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          vis_q[g] <= RST_CODE;
        else if (ld_en && (ld_sel == 3'(g))) vis_q[g] <= ld_data;
        else if (win_end && !set_mode)       vis_q[g] <= fresh[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q     <= 1'b0;
      alarm_req <= 1'b0;
      upd_req   <= 1'b0;
    end else begin
      set_q     <= set_mode;
      alarm_req <= win_end && alarm_en && alarm_hit;
      upd_req   <= win_end && upd_en;
    end
  end

  assign out_sec  = vis_q[FLD_SEC];
  assign out_min  = vis_q[FLD_MIN];
  assign out_hr   = vis_q[FLD_HR];
  assign out_wday = vis_q[FLD_WDAY];
  assign out_mday = vis_q[FLD_MDAY];
  assign out_mon  = vis_q[FLD_MON];
  assign out_yr   = vis_q[FLD_YR];

endmodule

// File: rtl/cal_bcd_clock_chk.sv
module cal_bcd_clock_chk
  import cal_bcd_pkg::*;
#(
  parameter int UIP_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  osc_sel,
  input logic        set_mode,
  input logic        ld_en,
  input logic        alarm_en,
  input logic        upd_en,
  input logic        reload,
  input logic        win_end,
  input logic        uip,
  input logic        alarm_req,
  input logic        upd_req,
  input cal_time_t   cur_time,
  input logic [55:0] vis_bus
);

  logic [15:0] uip_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  uip_run_q <= '0;
    else if (!uip)               uip_run_q <= '0;
    else if (uip_run_q != '1)    uip_run_q <= uip_run_q + 16'd1;
  end

  // R2: stopped oscillator keeps the internal time unless the host reloads it
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_sel != OSC_RUN && !reload) |=> $stable(cur_time));

  // R3: the update-in-progress window never exceeds its length
  p_uip_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uip_run_q <= 16'(UIP_CYCLES));

  // R3: requests only follow the end of a window
  p_req_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_req || upd_req) |-> $past(win_end));

  // R9: alarm requests need the enable
  p_alarm_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_req |-> $past(alarm_en));

  // R10: update-ended requests need the enable and last one cycle
  p_upd_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> $past(upd_en));
  p_upd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> !upd_req);

  // R11: SET keeps the visible bytes and clears the in-progress flag
  p_set_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !ld_en) |=> $stable(vis_bus));
  p_set_nouip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> !uip);

endmodule

bind cal_bcd_clock cal_bcd_clock_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_sel   (osc_sel),
  .set_mode  (set_mode),
  .ld_en     (ld_en),
  .alarm_en  (alarm_en),
  .upd_en    (upd_en),
  .reload    (reload),
  .win_end   (win_end),
  .uip       (uip),
  .alarm_req (alarm_req),
  .upd_req   (upd_req),
  .cur_time  (cur_time),
  .vis_bus   ({out_sec, out_min, out_hr, out_wday, out_mday, out_mon, out_yr})
);

// File: tb/cal_bcd_clock_tb.sv
module cal_bcd_clock_tb;

  localparam int UIP = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick, set_mode, bin_mode, h24_mode, alarm_en, upd_en, ld_en;
  logic [2:0] osc_sel, ld_sel;
  logic [7:0] alarm_sec, alarm_min, alarm_hr, ld_data;
  logic [7:0] out_sec, out_min, out_hr, out_wday, out_mday, out_mon, out_yr;
  logic       uip, alarm_req, upd_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  int m_sec, m_min, m_hr, m_wday, m_mday, m_mon, m_yr;
  bit a_wild [3];
  int a_val  [3];

  always #10 clk = ~clk;

  cal_bcd_clock #(.UIP_CYCLES(UIP), .CENTURY(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_sel(osc_sel),
    .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .alarm_en(alarm_en), .upd_en(upd_en), .alarm_sec(alarm_sec),
    .alarm_min(alarm_min), .alarm_hr(alarm_hr), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .out_sec(out_sec), .out_min(out_min), .out_hr(out_hr),
    .out_wday(out_wday), .out_mday(out_mday), .out_mon(out_mon), .out_yr(out_yr),
    .uip(uip), .alarm_req(alarm_req), .upd_req(upd_req)
  );

  function automatic int b_enc(int v, bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int b_hr(int h, bit bin, bit h24);
    if (h24) return b_enc(h, bin);
    return b_enc(h % 12, bin) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int b_dim(int mo, int y);
    int full;
    full = 2000 + y;
    if (mo == 2) return ((full % 400 == 0) || (full % 4 == 0 && full % 100 != 0)) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic b_step();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin
      m_min = 0; m_hr++;
      if (m_hr == 24) begin
        m_hr = 0;
        m_wday = (m_wday + 1) % 7;
        if (m_mday + 1 > b_dim(m_mon, m_yr)) begin
          m_mday = 1; m_mon++;
          if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end else m_mday++;
      end
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_fields(string req);
    chk({req, " sec"},  out_sec,  b_enc(m_sec, bin_mode));
    chk({req, " min"},  out_min,  b_enc(m_min, bin_mode));
    chk({req, " hr"},   out_hr,   b_hr(m_hr, bin_mode, h24_mode));
    chk({req, " wday"}, out_wday, b_enc(m_wday, bin_mode));
    chk({req, " mday"}, out_mday, b_enc(m_mday, bin_mode));
    chk({req, " mon"},  out_mon,  b_enc(m_mon, bin_mode));
    chk({req, " yr"},   out_yr,   b_enc(m_yr, bin_mode));
  endtask

  task automatic load_field(int sel, int data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'(sel); ld_data = 8'(data);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // R11/R12: all fields written under SET, then SET released to resync
  task automatic set_time(bit bin, bit h24, int s, int mi, int h, int wd, int md,
                          int mo, int y);
    m_sec = s; m_min = mi; m_hr = h; m_wday = wd; m_mday = md; m_mon = mo; m_yr = y;
    @(negedge clk);
    bin_mode = bin; h24_mode = h24; set_mode = 1'b1;
    load_field(0, b_enc(s, bin));
    load_field(1, b_enc(mi, bin));
    load_field(2, b_hr(h, bin, h24));
    load_field(3, b_enc(wd, bin));
    load_field(4, b_enc(md, bin));
    load_field(5, b_enc(mo, bin));
    load_field(6, b_enc(y, bin));
    @(negedge clk) set_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_alarm(bit ws, int vs, bit wm, int vm, bit wh, int vh);
    a_wild[0] = ws; a_val[0] = vs;
    a_wild[1] = wm; a_val[1] = vm;
    a_wild[2] = wh; a_val[2] = vh;
    alarm_sec = ws ? 8'(8'hC0 | $urandom_range(0, 63)) : 8'(b_enc(vs, bin_mode));
    alarm_min = wm ? 8'(8'hC0 | $urandom_range(0, 63)) : 8'(b_enc(vm, bin_mode));
    alarm_hr  = wh ? 8'(8'hC0 | $urandom_range(0, 63)) : 8'(b_hr(vh, bin_mode, h24_mode));
  endtask

  function automatic bit alarm_expect();
    return alarm_en && (a_wild[0] || a_val[0] == m_sec) &&
           (a_wild[1] || a_val[1] == m_min) && (a_wild[2] || a_val[2] == m_hr);
  endfunction

  // pulse the second input; returns after the window-ending edge
  task automatic do_tick(bit extra, output int ucnt, output bit a, output bit u);
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    ucnt = 0;
    for (int k = 0; k < UIP; k++) begin
      if (uip) ucnt++;
      sec_tick = (extra && k == 1);
      @(negedge clk);
    end
    sec_tick = 1'b0;
    a = alarm_req;
    u = upd_req;
  endtask

  task automatic tick_check(string req, bit extra);
    int ucnt; bit a, u;
    do_tick(extra, ucnt, a, u);
    b_step();
    check_fields(req);
    chk({req, " R3 uip cycles"}, ucnt, UIP);
    chk({req, " R10 upd_req"}, u, upd_en);
    chk({req, " R9 alarm_req"}, a, alarm_expect());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int ucnt; bit a, u;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sec_tick = 0; set_mode = 0; bin_mode = 0; h24_mode = 1;
    alarm_en = 0; upd_en = 0; ld_en = 0; ld_sel = 0; ld_data = 0;
    osc_sel = 3'b010; alarm_sec = 0; alarm_min = 0; alarm_hr = 0;
    a_wild[0] = 1; a_wild[1] = 1; a_wild[2] = 1;
    a_val[0] = 0; a_val[1] = 0; a_val[2] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sec", out_sec, 0);   chk("R1 min", out_min, 0);   chk("R1 hr", out_hr, 0);
    chk("R1 wday", out_wday, 0); chk("R1 mday", out_mday, 1); chk("R1 mon", out_mon, 1);
    chk("R1 yr", out_yr, 0);     chk("R1 uip", uip, 0);
    chk("R1 alarm_req", alarm_req, 0); chk("R1 upd_req", upd_req, 0);

    // R12 load and plain counting R6
    upd_en = 1'b1;
    set_time(0, 1, 30, 20, 10, 3, 15, 6, 24);
    check_fields("R12 load under SET");
    tick_check("R6 plain second", 0);

    // R3 pulse inside an open window is ignored
    tick_check("R3 extra tick ignored", 1);

    // R2 stopped oscillator
    @(negedge clk) osc_sel = 3'b110;
    do_tick(0, ucnt, a, u);
    check_fields("R2 frozen");
    chk("R2 uip", ucnt, 0);
    chk("R2 upd_req", u, 0);
    @(negedge clk) osc_sel = 3'b010;

    // R5 12-hour format
    set_time(0, 0, 59, 59, 11, 2, 10, 3, 30);
    chk("R5 11 AM code", out_hr, 8'h11);
    tick_check("R5 noon", 0);
    chk("R5 noon code", out_hr, 8'h80);
    set_time(0, 0, 59, 59, 23, 2, 10, 3, 30);
    chk("R5 11 PM code", out_hr, 8'h91);
    tick_check("R5 midnight", 0);

    // R7 month lengths, R4 binary
    set_time(1, 1, 59, 59, 23, 2, 28, 2, 0);
    tick_check("R7 R4 century leap", 0);
    chk("R7 feb 29 binary", out_mday, 29);
    set_time(1, 1, 59, 59, 23, 2, 28, 2, 23);
    tick_check("R7 common year", 0);
    set_time(0, 1, 59, 59, 23, 2, 28, 2, 24);
    tick_check("R7 R4 leap bcd", 0);
    chk("R4 bcd 29", out_mday, 8'h29);

    // R6 year rollover
    set_time(0, 1, 59, 59, 23, 6, 31, 12, 99);
    tick_check("R6 new year", 0);

    // R8 zero day-of-month
    set_time(0, 1, 59, 59, 23, 1, 0, 5, 10);
    tick_check("R8 zero day", 0);

    // R9 alarm exact and wildcard
    set_time(0, 0, 58, 30, 14, 1, 5, 5, 10);
    alarm_en = 1'b1;
    set_alarm(0, 59, 1, 0, 0, 14);
    tick_check("R9 exact match", 0);
    tick_check("R9 miss", 0);
    set_alarm(1, 0, 1, 0, 1, 0);
    tick_check("R9 all wildcard", 0);

    // R11 SET hides the update but time advances inside
    set_time(0, 1, 10, 0, 8, 1, 5, 5, 10);
    set_alarm(0, 11, 1, 0, 1, 0);
    @(negedge clk) set_mode = 1'b1;
    do_tick(0, ucnt, a, u);
    check_fields("R11 visible frozen");
    chk("R11 uip stays low", ucnt, 0);
    chk("R11 internal advances alarm", a, 1);
    chk("R11 upd_req", u, 1);
    @(negedge clk) set_mode = 1'b0;
    @(negedge clk);
    tick_check("R11 resync from visible", 0);

    // R12 direct load with SET low
    load_field(0, b_enc(45, bin_mode));
    m_sec = 45;
    check_fields("R12 direct load");
    tick_check("R12 after direct load", 0);

    // random near-boundary runs
    for (int it = 0; it < 40; it++) begin
      int mo, yy, md, dim;
      bit bn, hh;
      bn = 1'($urandom_range(0, 1));
      hh = 1'($urandom_range(0, 1));
      mo = $urandom_range(1, 12);
      yy = $urandom_range(0, 99);
      dim = b_dim(mo, yy);
      md = ($urandom_range(0, 1) == 1) ? dim : $urandom_range(1, dim);
      set_time(bn, hh, $urandom_range(56, 59),
               ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59),
               ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23),
               $urandom_range(0, 6), md, mo, yy);
      alarm_en = 1'($urandom_range(0, 1));
      upd_en   = 1'($urandom_range(0, 1));
      set_alarm(1'($urandom_range(0, 1)), (m_sec + $urandom_range(1, 2)) % 60,
                1'($urandom_range(0, 1)), $urandom_range(0, 1) == 1 ? 0 : m_min,
                1'($urandom_range(0, 1)), $urandom_range(0, 1) == 1 ? 0 : m_hr);
      for (int t = 0; t < 3; t++) tick_check("R6 R9 R10 random", 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule